// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

A full-duplex asynchronous transceiver built around one 16x oversampled bit clock. Three frame modes share the datapath. An 8-bit mode sends a start bit, eight data bits and a stop bit. Two 9-bit modes insert an extra bit, taken from a transmit-side input, between the data and the stop bit. The two 9-bit modes differ only in bit rate. The fixed-rate 9-bit mode divides the system clock by 16 or 32, as a double-rate input selects. The 8-bit mode and the variable-rate 9-bit mode count a 16x tick taken from one of two external tick inputs.

The receiver synchronises the line and detects a start edge. It decides each bit by majority vote over three samples at the middle of the bit. What it keeps in its extra-bit register depends on the mode: the stop bit in the 8-bit mode, the ninth bit in the 9-bit modes. Transmit-done, receive-done and framing-error flags set in hardware and clear only on their clear inputs. A control read bit shows either the upper mode bit or the framing error, as a view-select input chooses.

Top module: `sio_port`

## Requirements
- R1: In mode_i = 2'b01 the transmitter drives a 10-bit frame: one 0, then tx_data_i LSB first, then one 1. Each bit lasts 16 selected ticks. The line idles at 1.
- R2: In mode_i = 2'b10 and 2'b11 the frame has 11 bits: start 0, eight data bits LSB first, tx_bit9_i, then a stop 1.
- R3: In mode_i = 2'b01 the receiver puts the sampled stop bit into rx_bit8_o.
- R4: In mode_i = 2'b10 and 2'b11 the receiver puts the ninth bit into rx_bit8_o. The stop bit does not reach rx_bit8_o.
- R5: In mode_i = 2'b10 one bit lasts 16 clock cycles when dbl_rate_i = 1 and 32 cycles when it is 0.
- R6: In mode_i = 2'b01 and 2'b11 the 16x tick is tick_a_i when baud_sel_i = 0 and tick_b_i when it is 1.
- R7: fe_o sets when a sampled stop bit is 0. It stays set until fe_clr_i is pulsed.
- R8: ctrl_top_o equals fe_o when fe_view_i = 1, and mode_i[1] when fe_view_i = 0.
- R9: Each received bit is the majority of samples 7, 8 and 9 of its 16. A start bit that votes 1 is dropped, and no frame is reported.
- R10: ti_o sets when the stop bit begins on tx_o. ri_o sets at the stop-bit vote, and rx_data_o and rx_bit8_o update at the same moment. Each flag clears only on its clear input.
- R11: A tx_start_i pulse while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 01 8-bit, 10 9-bit fixed rate, 11 9-bit variable rate, 00 off |
| dbl_rate_i | input | 1 | Fixed-rate mode: 1 gives clk/16, 0 gives clk/32 |
| baud_sel_i | input | 1 | Tick source for modes 01 and 11 |
| tick_a_i | input | 1 | External 16x tick, source 0 |
| tick_b_i | input | 1 | External 16x tick, source 1 |
| fe_view_i | input | 1 | Selects framing error onto ctrl_top_o |
| tx_start_i | input | 1 | Start pulse, loads tx_data_i and tx_bit9_i |
| tx_data_i | input | 8 | Byte to send |
| tx_bit9_i | input | 1 | Ninth bit to send |
| ti_clr_i | input | 1 | Clears ti_o |
| ri_clr_i | input | 1 | Clears ri_o |
| fe_clr_i | input | 1 | Clears fe_o |
| rx_i | input | 1 | Serial input line |
| tx_o | output | 1 | Serial output line |
| rx_data_o | output | 8 | Last received byte |
| rx_bit8_o | output | 1 | Received extra bit |
| ti_o | output | 1 | Transmit-done flag |
| ri_o | output | 1 | Receive-done flag |
| fe_o | output | 1 | Framing-error flag |
| ctrl_top_o | output | 1 | Mode bit or framing error, per fe_view_i |

## Verification
A transmitted frame starts one cycle after tx_start_i. Each later bit arrives 16 ticks after the previous one, with up to one tick of phase jitter. The bench therefore waits for the falling start edge on tx_o and samples every bit at its centre, which leaves half a bit of margin. A received frame reports on ri_o two synchroniser cycles plus nine ticks after the stop bit begins, so a monitor pops expected items whenever ri_o rises rather than at a fixed cycle. Static outputs such as fe_o and ctrl_top_o are sampled at a falling clock edge after the frame has fully ended.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_8B     = 2'b01,
    MODE_9B_FIX = 2'b10,
    MODE_9B_VAR = 2'b11
  } sio_mode_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sio_tick.sv
module sio_tick
  import sio_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sio_mode_e mode_i,
  input  logic      dbl_rate_i,
  input  logic      baud_sel_i,
  input  logic      tick_a_i,
  input  logic      tick_b_i,
  output logic      tick_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= 1'b0;
    else if (mode_i == MODE_9B_FIX) div_q <= ~div_q;
    else                          div_q <= 1'b0;
  end

  always_comb begin
    unique case (mode_i)
      MODE_9B_FIX:         tick_o = dbl_rate_i | div_q;
      MODE_8B, MODE_9B_VAR: tick_o = baud_sel_i ? tick_b_i : tick_a_i;
      default:             tick_o = 1'b0;
    endcase
  end

  AST_HALF_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && mode_i == MODE_9B_FIX && !dbl_rate_i) |=>
      (mode_i != MODE_9B_FIX || dbl_rate_i || !tick_o)); // R5
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          nine_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          bit9_i,
  input  logic          ti_clr_i,
  output logic          tx_o,
  output logic          ti_o,
  output logic          busy_o
);
  localparam int CW = $clog2(OSR);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] ocnt_q;
  logic [BW-1:0] bidx_q;
  logic          busy_q, ti_q;
  logic [BW-1:0] last;
  logic          bit_end;

  assign last    = nine_i ? BW'(DW + 2) : BW'(DW + 1);
  assign bit_end = busy_q && tick_i && (ocnt_q == CW'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      ocnt_q <= '0;
      bidx_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, (nine_i ? bit9_i : 1'b1), data_i, 1'b0};
        ocnt_q <= '0;
        bidx_q <= '0;
      end
    end else if (tick_i) begin
      if (ocnt_q == CW'(OSR - 1)) begin
        ocnt_q <= '0;
        if (bidx_q == last) begin
          busy_q <= 1'b0;
        end else begin
          bidx_q <= bidx_q + 1'b1;
          sh_q   <= {1'b1, sh_q[FW-1:1]};
        end
      end else begin
        ocnt_q <= ocnt_q + 1'b1;
      end
    end
  end

  // done flag rises as the stop bit goes out; set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ti_q <= 1'b0;
    else if (bit_end && bidx_q == last - 1'b1) ti_q <= 1'b1;
    else if (ti_clr_i)                         ti_q <= 1'b0;
  end

  assign tx_o   = ~busy_q | sh_q[0];
  assign ti_o   = ti_q;
  assign busy_o = busy_q;

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tx_o)); // R1
  AST_TI_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ti_o) |-> (tx_o && busy_o)); // R10
  AST_BUSY_HOLDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick_i) |=> $stable(tx_o)); // R11
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          nine_i,
  input  logic          rx_i,
  input  logic          ri_clr_i,
  input  logic          fe_clr_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_bit8_o,
  output logic          ri_o,
  output logic          fe_o
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int BW  = $clog2(DW + 4);

  logic          s1_q, rxs_q;
  logic          active_q;
  logic [CW-1:0] ocnt_q;
  logic [BW-1:0] bidx_q;
  logic [1:0]    smp_q;
  logic [DW-1:0] dat_q;
  logic          ninth_q;
  logic [DW-1:0] out_q;
  logic          b8_q, ri_q, fe_q;
  logic [BW-1:0] last;
  logic          vote_now, bit_v, done;

  assign last     = nine_i ? BW'(DW + 2) : BW'(DW + 1);
  assign vote_now = active_q && tick_i && (ocnt_q == CW'(MID + 1));
  assign bit_v    = maj3(smp_q[0], smp_q[1], rxs_q);
  assign done     = vote_now && (bidx_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b1;
      rxs_q <= 1'b1;
    end else begin
      s1_q  <= rx_i;
      rxs_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ocnt_q   <= '0;
      bidx_q   <= '0;
      smp_q    <= '0;
      dat_q    <= '0;
      ninth_q  <= 1'b0;
    end else if (tick_i) begin
      if (!active_q) begin
        if (!rxs_q) begin
          active_q <= 1'b1;
          ocnt_q   <= '0;
          bidx_q   <= '0;
        end
      end else begin
        ocnt_q <= (ocnt_q == CW'(OSR - 1)) ? '0 : ocnt_q + 1'b1;
        if (ocnt_q == CW'(MID - 1)) smp_q[0] <= rxs_q;
        if (ocnt_q == CW'(MID))     smp_q[1] <= rxs_q;
        if (vote_now) begin
          if (bidx_q == '0 && bit_v) begin
            active_q <= 1'b0;                 // false start
          end else if (done) begin
            active_q <= 1'b0;
          end else begin
            if (bidx_q <= BW'(DW)) dat_q   <= {bit_v, dat_q[DW-1:1]};
            else                   ninth_q <= bit_v;
            bidx_q <= bidx_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      b8_q  <= 1'b0;
    end else if (done) begin
      out_q <= dat_q;
      b8_q  <= nine_i ? ninth_q : bit_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ri_q <= 1'b0;
    else if (done)     ri_q <= 1'b1;
    else if (ri_clr_i) ri_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               fe_q <= 1'b0;
    else if (done && !bit_v)   fe_q <= 1'b1;
    else if (fe_clr_i)         fe_q <= 1'b0;
  end

  assign rx_data_o = out_q;
  assign rx_bit8_o = b8_q;
  assign ri_o      = ri_q;
  assign fe_o      = fe_q;

  AST_M8_STOP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ri_o) && !nine_i && !$past(fe_o)) |-> (rx_bit8_o == !fe_o)); // R3
  AST_FE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !fe_clr_i) |=> fe_o); // R7
  AST_RI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_o && !ri_clr_i) |=> ri_o); // R10
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          dbl_rate_i,
  input  logic          baud_sel_i,
  input  logic          tick_a_i,
  input  logic          tick_b_i,
  input  logic          fe_view_i,
  input  logic          tx_start_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_bit9_i,
  input  logic          ti_clr_i,
  input  logic          ri_clr_i,
  input  logic          fe_clr_i,
  input  logic          rx_i,
  output logic          tx_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_bit8_o,
  output logic          ti_o,
  output logic          ri_o,
  output logic          fe_o,
  output logic          ctrl_top_o
);
  sio_mode_e mode;
  logic      tick, nine, tx_busy, fe;

  assign mode = sio_mode_e'(mode_i);
  assign nine = mode_i[1];

  sio_tick u_tick (
    .clk_i, .rst_ni, .mode_i(mode), .dbl_rate_i, .baud_sel_i,
    .tick_a_i, .tick_b_i, .tick_o(tick)
  );

  sio_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .nine_i(nine), .start_i(tx_start_i),
    .data_i(tx_data_i), .bit9_i(tx_bit9_i), .ti_clr_i,
    .tx_o, .ti_o, .busy_o(tx_busy)
  );

  sio_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .nine_i(nine), .rx_i,
    .ri_clr_i, .fe_clr_i, .rx_data_o, .rx_bit8_o, .ri_o, .fe_o(fe)
  );

  assign fe_o       = fe;
  assign ctrl_top_o = fe_view_i ? fe : mode_i[1];

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy && !tx_start_i) |=> tx_o); // R1
endmodule

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] d;
    logic       b8;
    logic       fe;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       dbl = 1'b0, bsel = 1'b0, tick_a = 1'b0, tick_b = 1'b0, fe_view = 1'b0;
  logic       tx_start = 1'b0, tx_b9 = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0, fe_clr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       loop_en = 1'b0, rx_drv = 1'b1;
  logic       rx_line, tx_o, rx_b8, ti, ri, fe, ctop;
  logic [7:0] rx_data;
  int         checks = 0, errors = 0, ca = 0, cb = 0;
  bit         done = 1'b0;
  exp_t       q[$];

  assign rx_line = loop_en ? tx_o : rx_drv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dbl_rate_i(dbl), .baud_sel_i(bsel),
    .tick_a_i(tick_a), .tick_b_i(tick_b), .fe_view_i(fe_view), .tx_start_i(tx_start),
    .tx_data_i(tx_data), .tx_bit9_i(tx_b9), .ti_clr_i(ti_clr), .ri_clr_i(ri_clr),
    .fe_clr_i(fe_clr), .rx_i(rx_line), .tx_o(tx_o), .rx_data_o(rx_data),
    .rx_bit8_o(rx_b8), .ti_o(ti), .ri_o(ri), .fe_o(fe), .ctrl_top_o(ctop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick_a every 3 cycles, tick_b every 2 cycles
  initial forever begin
    @(negedge clk);
    ca = (ca == 2) ? 0 : ca + 1;
    cb = (cb == 1) ? 0 : cb + 1;
    tick_a = (ca == 0);
    tick_b = (cb == 0);
  end

  // monitor: pop expected on each receive-done flag
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      ri_clr = 1'b0;
      if (rst_n && ri) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9/R11 actual=unexpected frame %0h expected=none", rx_data);
        end else begin
          e = q.pop_front();
          chk("R10 rx data", rx_data, e.d);
          chk("R3/R4 rx bit8", rx_b8, e.b8);
          chk("R7 fe", fe, e.fe);
        end
        ri_clr = 1'b1;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
    chk("R10 frame delivered", q.size(), 0);
    cyc(8);
  endtask

  // transmit one frame, check each bit at its centre; cpb = cycles per tick
  task automatic tx_frame(input logic [7:0] d, input logic b9, input int cpb, input string req);
    int  nb;
    logic exp_bit;
    int  w;
    nb = mode[1] ? 11 : 10;
    q.push_back('{d: d, b8: (mode[1] ? b9 : 1'b1), fe: 1'b0});
    tx_data = d; tx_b9 = b9; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    w = 0;
    while (tx_o !== 1'b0 && w < 100) begin @(negedge clk); w++; end
    cyc(cpb * 8);
    for (int k = 0; k < nb; k++) begin
      if (k == 0)                     exp_bit = 1'b0;
      else if (k <= 8)                exp_bit = d[k-1];
      else if (k == 9 && mode[1])     exp_bit = b9;
      else                            exp_bit = 1'b1;
      chk(req, {k[7:0], 7'd0, tx_o}, {k[7:0], 7'd0, exp_bit});
      if (k == 3) chk("R10 ti low mid-frame", ti, 0);
      if (k == 4) begin
        tx_data = ~d; tx_start = 1'b1;   // R11: ignored while busy
        @(negedge clk);
        tx_start = 1'b0;
        cyc(cpb * 16 - 1);
      end else if (k != nb - 1) begin
        cyc(cpb * 16);
      end
    end
    chk("R10 ti at stop", ti, 1);
    cyc(cpb * 16);
    chk("R10 ti held", ti, 1);
    ti_clr = 1'b1; @(negedge clk); ti_clr = 1'b0; @(negedge clk);
    chk("R10 ti cleared", ti, 0);
    drain();
  endtask

  // drive one frame on rx; glitch flips one tick at the centre of data bit 0
  task automatic rx_frame(input logic [7:0] d, input logic b9, input logic stop,
                          input int cpb, input bit glitch);
    int bt;
    bt = cpb * 16;
    q.push_back('{d: d, b8: (mode[1] ? b9 : stop), fe: ~stop});
    rx_drv = 1'b0; cyc(bt);
    for (int k = 0; k < 8; k++) begin
      rx_drv = d[k];
      if (glitch && k == 0) begin
        cyc(cpb * 8); rx_drv = ~d[k]; cyc(cpb); rx_drv = d[k]; cyc(bt - cpb * 9);
      end else cyc(bt);
    end
    if (mode[1]) begin rx_drv = b9; cyc(bt); end
    rx_drv = stop;
    if (stop) cyc(bt);
    else begin cyc(cpb * 11); rx_drv = 1'b1; cyc(cpb * 5); end
    cyc(cpb * 4);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 idle line", tx_o, 1);
    chk("R10 ri reset", ri, 0);
    chk("R10 ti reset", ti, 0);
    chk("R7 fe reset", fe, 0);
    chk("R8 ctrl bit shows mode", ctop, 0);

    // R2 R5: fixed-rate 9-bit, clk/16
    loop_en = 1'b1; mode = 2'b10; dbl = 1'b1; cyc(2);
    tx_frame(8'hA5, 1'b1, 1, "R2/R5 tx bit (16 cyc)");
    // R5: clk/32
    dbl = 1'b0; cyc(2);
    tx_frame(8'h3C, 1'b0, 2, "R5/R2 tx bit (32 cyc)");
    // R1 R6: 8-bit, tick_a
    mode = 2'b01; bsel = 1'b0; cyc(2);
    tx_frame(8'h81, 1'b1, 3, "R1/R6 tx bit");
    // R6: variable-rate 9-bit, tick_b
    mode = 2'b11; bsel = 1'b1; cyc(2);
    tx_frame(8'h5A, 1'b0, 2, "R6/R2 tx bit");

    // R4 R7: 9-bit receive with a bad stop
    loop_en = 1'b0; mode = 2'b11; bsel = 1'b0; cyc(4);
    rx_frame(8'h96, 1'b1, 1'b0, 3, 1'b0);
    cyc(100);
    chk("R7 fe sticky", fe, 1);
    fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0; @(negedge clk);
    chk("R7 fe cleared", fe, 0);

    // R3 R8: 8-bit receive with bad stop, then good
    mode = 2'b01; cyc(4);
    rx_frame(8'h42, 1'b0, 1'b0, 3, 1'b0);
    fe_view = 1'b1; @(negedge clk);
    chk("R8 ctrl bit shows fe", ctop, 1);
    fe_view = 1'b0; @(negedge clk);
    chk("R8 ctrl bit shows mode bit", ctop, 0);
    fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0; @(negedge clk);
    fe_view = 1'b1; @(negedge clk);
    chk("R8 ctrl bit fe cleared", ctop, 0);
    rx_frame(8'hC3, 1'b0, 1'b1, 3, 1'b0);

    // R9: false start then a glitched good frame
    rx_drv = 1'b0; cyc(15); rx_drv = 1'b1; cyc(300);
    chk("R9 false start dropped", ri, 0);
    rx_frame(8'h7E, 1'b0, 1'b1, 3, 1'b1);
    // R4: fixed-rate receive, ninth 0
    mode = 2'b10; dbl = 1'b1; cyc(4);
    rx_frame(8'h0F, 1'b0, 1'b1, 1, 1'b0);

    cyc(20);
    chk("R11 no extra frames", q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule